// File: doc/BRIEF.md
# Per-Frame Saturation and Peak Monitor

This block sits on a stream of signed I/Q samples that feeds a gain-control loop. Each sample carries a qualifier and two overflow flags, one per channel. Over the length of a frame the block keeps two running statistics: how many qualified samples showed an overflow on either channel, and the largest per-sample magnitude seen. A single-cycle frame strobe hands both figures to the gain loop as a held snapshot, with a one-cycle pulse that marks them as fresh. Accumulation then restarts from zero.

A sample that arrives in the same cycle as the frame strobe is counted in the snapshot being taken. It is not dropped, and it is not carried into the next frame. The event counter stops at its all-ones value instead of wrapping. The samples also pass through a one-stage register, so the consumer of the stream sees the data aligned one clock behind the inputs.

The design has no state machine. The two accumulators and the snapshot registers are its only state, and they are updated by two separate clocked processes.

Top module: `frame_sat_peak_mon`

## Requirements
- R1: The magnitude of each channel is a 15-bit unsigned value. A non-negative input passes through unchanged and a negative input is negated. The one negative code with no positive counterpart, 0x8000, maps to 0x7FFF.
- R2: The magnitude of a sample is the larger of the I and Q channel magnitudes.
- R3: The running peak takes the sample magnitude only when `valid_in` is high and the magnitude is strictly greater than the stored peak. Samples with `valid_in` low leave the peak unchanged.
- R4: The event count rises by one for each sample that has `valid_in` high and either `ovf_i` or `ovf_q` set. It holds at 255 (0xFF) once it reaches that value. Overflow flags on a sample with `valid_in` low are ignored.
- R5: `snap_valid` is high for exactly the one clock after each clock edge at which `frame_boundary` was sampled high, and is low at all other times.
- R6: At a frame strobe, `snap_sat_count` and `snap_peak` take the frame's totals and both accumulators restart at zero. The snapshot outputs hold their values until the next frame strobe.
- R7: A qualified sample in the same cycle as `frame_boundary` is included in the snapshot. Its overflow increment and its peak update are both applied. It contributes nothing to the following frame.
- R8: `valid_out`, `sample_i_out` and `sample_q_out` equal `valid_in`, `sample_i` and `sample_q` delayed by one clock.
- R9: An active-low asynchronous `rst_n` clears the accumulators, the snapshot outputs, `snap_valid` and the delayed sample outputs to zero at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Sample qualifier |
| sample_i | input | 16 | I sample, two's complement |
| sample_q | input | 16 | Q sample, two's complement |
| ovf_i | input | 1 | Overflow flag for the I channel |
| ovf_q | input | 1 | Overflow flag for the Q channel |
| frame_boundary | input | 1 | Single-cycle frame strobe |
| valid_out | output | 1 | `valid_in` delayed by one clock |
| sample_i_out | output | 16 | `sample_i` delayed by one clock |
| sample_q_out | output | 16 | `sample_q` delayed by one clock |
| snap_sat_count | output | 8 | Overflow event count of the last completed frame |
| snap_peak | output | 15 | Peak magnitude of the last completed frame |
| snap_valid | output | 1 | One-cycle pulse that marks a fresh snapshot |

## Verification
The bench targets a sample that coincides with the frame strobe. A design that handled this case wrongly would either drop the sample from the snapshot or let it leak into the next frame's totals.

It drives more than 255 overflow samples into one frame. A counter that wrapped would report a small number instead of 255.

It feeds the code 0x8000 and samples whose Q magnitude is larger than their I magnitude. A naive negation would report a peak of zero for 0x8000, and a channel-select error would report the smaller of the two magnitudes.

It also sends unqualified samples with large values and with overflow flags set. A design that ignored `valid_in` would show these in the snapshot. Finally it applies reset in the middle of a frame, which catches any accumulator left uncleared.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
    // Default widths shared by all modules of the monitor
    localparam int unsigned FSP_SAMPLE_W = 16;
    localparam int unsigned FSP_COUNT_W  = 8;

    // Index of each channel inside the packed sample pair
    typedef enum logic {
        CH_I = 1'b0,
        CH_Q = 1'b1
    } fsp_chan_e;
endpackage

// File: rtl/fsp_magnitude.sv
module fsp_magnitude #(
    parameter int unsigned SAMPLE_W = fsp_pkg::FSP_SAMPLE_W
) (
    input  logic [SAMPLE_W-1:0] smp_i,
    input  logic [SAMPLE_W-1:0] smp_q,
    output logic [SAMPLE_W-2:0] mag
);
    localparam int unsigned MAG_W = SAMPLE_W - 1;
    localparam logic [MAG_W-1:0] MAG_ONE = {{(MAG_W-1){1'b0}}, 1'b1};

    logic [1:0][SAMPLE_W-1:0] chan_in;
    assign chan_in[fsp_pkg::CH_I] = smp_i;
    assign chan_in[fsp_pkg::CH_Q] = smp_q;

    // One magnitude unit per channel
    for (genvar c = 0; c < 2; c++) begin : g_ch
        logic [MAG_W-1:0] low_bits;
        logic [MAG_W-1:0] m;
        assign low_bits = chan_in[c][MAG_W-1:0];
        always_comb begin
            if (!chan_in[c][SAMPLE_W-1]) begin
                m = low_bits;
            end else if (low_bits == '0) begin
                m = '1;                       // most negative code clamps
            end else begin
                m = ~low_bits + MAG_ONE;
            end
        end
    end

    assign mag = (g_ch[1].m > g_ch[0].m) ? g_ch[1].m : g_ch[0].m;

    always_comb begin
        AST_MAG_DOMINATES: assert (mag >= g_ch[0].m && mag >= g_ch[1].m); // R2
    end
endmodule

// File: rtl/fsp_delay.sv
module fsp_delay #(
    parameter int unsigned SAMPLE_W = fsp_pkg::FSP_SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid_in,
    input  logic [SAMPLE_W-1:0] d_i,
    input  logic [SAMPLE_W-1:0] d_q,
    output logic                valid_out,
    output logic [SAMPLE_W-1:0] q_i,
    output logic [SAMPLE_W-1:0] q_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_out <= 1'b0;
            q_i       <= '0;
            q_q       <= '0;
        end else begin
            valid_out <= valid_in;
            q_i       <= d_i;
            q_q       <= d_q;
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (valid_out == $past(valid_in))); // R8
endmodule

// File: rtl/fsp_accum.sv
module fsp_accum #(
    parameter int unsigned PEAK_W  = fsp_pkg::FSP_SAMPLE_W - 1,
    parameter int unsigned COUNT_W = fsp_pkg::FSP_COUNT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid_in,
    input  logic               ovf_any,
    input  logic [PEAK_W-1:0]  mag,
    input  logic               frame_boundary,
    output logic [COUNT_W-1:0] snap_cnt,
    output logic [PEAK_W-1:0]  snap_peak,
    output logic               snap_valid
);
    localparam logic [COUNT_W-1:0] CNT_MAX = '1;
    localparam logic [COUNT_W-1:0] CNT_ONE = {{(COUNT_W-1){1'b0}}, 1'b1};

    logic [COUNT_W-1:0] acc_cnt;
    logic [PEAK_W-1:0]  acc_peak;
    logic               bump_cnt;
    logic               bump_peak;
    logic [COUNT_W-1:0] cnt_next;
    logic [PEAK_W-1:0]  peak_next;

    // Decisions from current inputs and the registered accumulators
    assign bump_cnt  = valid_in && ovf_any && (acc_cnt != CNT_MAX);
    assign bump_peak = valid_in && (mag > acc_peak);
    assign cnt_next  = bump_cnt ? (acc_cnt + CNT_ONE) : acc_cnt;
    assign peak_next = bump_peak ? mag : acc_peak;

    // Accumulator process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_cnt  <= '0;
            acc_peak <= '0;
        end else if (frame_boundary) begin
            acc_cnt  <= '0;
            acc_peak <= '0;
        end else begin
            acc_cnt  <= cnt_next;
            acc_peak <= peak_next;
        end
    end

    // Snapshot process; includes a sample coincident with the strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_cnt   <= '0;
            snap_peak  <= '0;
            snap_valid <= 1'b0;
        end else begin
            snap_valid <= frame_boundary;
            if (frame_boundary) begin
                snap_cnt  <= cnt_next;
                snap_peak <= peak_next;
            end
        end
    end

    AST_PEAK_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_boundary |=> (acc_peak >= $past(acc_peak))); // R3
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_boundary |=> (acc_cnt == $past(acc_cnt) || acc_cnt == $past(acc_cnt) + CNT_ONE)); // R4
    AST_COUNT_HOLDS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_cnt == CNT_MAX && !frame_boundary) |=> (acc_cnt == CNT_MAX)); // R4
    AST_PULSE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_boundary |=> snap_valid); // R5
    AST_NO_STRAY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_boundary |=> !snap_valid); // R5
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        frame_boundary |=> (acc_cnt == '0 && acc_peak == '0)); // R6
    AST_SNAPSHOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_boundary |=> ($stable(snap_cnt) && $stable(snap_peak))); // R6
endmodule

// File: rtl/frame_sat_peak_mon.sv
module frame_sat_peak_mon #(
    parameter int unsigned SAMPLE_W = fsp_pkg::FSP_SAMPLE_W,
    parameter int unsigned COUNT_W  = fsp_pkg::FSP_COUNT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid_in,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic [SAMPLE_W-1:0] sample_q,
    input  logic                ovf_i,
    input  logic                ovf_q,
    input  logic                frame_boundary,
    output logic                valid_out,
    output logic [SAMPLE_W-1:0] sample_i_out,
    output logic [SAMPLE_W-1:0] sample_q_out,
    output logic [COUNT_W-1:0]  snap_sat_count,
    output logic [SAMPLE_W-2:0] snap_peak,
    output logic                snap_valid
);
    localparam int unsigned PEAK_W = SAMPLE_W - 1;

    logic [PEAK_W-1:0] sample_mag;

    fsp_magnitude #(.SAMPLE_W(SAMPLE_W)) u_mag (
        .smp_i (sample_i),
        .smp_q (sample_q),
        .mag   (sample_mag)
    );

    fsp_accum #(.PEAK_W(PEAK_W), .COUNT_W(COUNT_W)) u_acc (
        .clk            (clk),
        .rst_n          (rst_n),
        .valid_in       (valid_in),
        .ovf_any        (ovf_i | ovf_q),
        .mag            (sample_mag),
        .frame_boundary (frame_boundary),
        .snap_cnt       (snap_sat_count),
        .snap_peak      (snap_peak),
        .snap_valid     (snap_valid)
    );

    fsp_delay #(.SAMPLE_W(SAMPLE_W)) u_dly (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_in  (valid_in),
        .d_i       (sample_i),
        .d_q       (sample_q),
        .valid_out (valid_out),
        .q_i       (sample_i_out),
        .q_q       (sample_q_out)
    );
endmodule

// File: tb/frame_sat_peak_mon_test.sv
module frame_sat_peak_mon_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [15:0] sample_i = '0;
    logic [15:0] sample_q = '0;
    logic        ovf_i = 1'b0;
    logic        ovf_q = 1'b0;
    logic        frame_boundary = 1'b0;
    logic        valid_out;
    logic [15:0] sample_i_out;
    logic [15:0] sample_q_out;
    logic [7:0]  snap_sat_count;
    logic [14:0] snap_peak;
    logic        snap_valid;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // reference model state
    int m_cnt = 0, m_peak = 0;
    int e_sc = 0, e_sp = 0, e_sv = 0, e_vo = 0, e_io = 0, e_qo = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_sat_peak_mon uut (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in),
        .sample_i(sample_i), .sample_q(sample_q),
        .ovf_i(ovf_i), .ovf_q(ovf_q), .frame_boundary(frame_boundary),
        .valid_out(valid_out), .sample_i_out(sample_i_out),
        .sample_q_out(sample_q_out), .snap_sat_count(snap_sat_count),
        .snap_peak(snap_peak), .snap_valid(snap_valid)
    );

    function automatic int ref_mag(input logic [15:0] s);
        int v;
        v = int'(s);
        if (v < 32768) return v;
        if (v == 32768) return 32767;   // R1 clamp
        return 65536 - v;
    endfunction

    task automatic chk(input string tag, input int act, input int exp, input string scn);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s (%s): actual %0d expected %0d at %0t", tag, scn, act, exp, $time);
        end
    endtask

    task automatic check_all(input string scn);
        chk("R5", int'(snap_valid), e_sv, scn);
        chk("R4", int'(snap_sat_count), e_sc, scn);
        chk("R3", int'(snap_peak), e_sp, scn);
        chk("R8", int'(valid_out), e_vo, scn);
        chk("R8", int'(sample_i_out), e_io, scn);
        chk("R8", int'(sample_q_out), e_qo, scn);
    endtask

    task automatic step(input logic v, input logic [15:0] i, input logic [15:0] q,
                        input logic oi, input logic oq, input logic fb, input string scn);
        int mi, mq, m, n_cnt, n_peak;
        valid_in = v; sample_i = i; sample_q = q;
        ovf_i = oi; ovf_q = oq; frame_boundary = fb;
        mi = ref_mag(i); mq = ref_mag(q);
        m = (mi > mq) ? mi : mq;
        n_cnt  = m_cnt + ((v && (oi || oq) && m_cnt < 255) ? 1 : 0);
        n_peak = (v && m > m_peak) ? m : m_peak;
        if (fb) begin
            e_sc = n_cnt; e_sp = n_peak; e_sv = 1;
            m_cnt = 0; m_peak = 0;
        end else begin
            m_cnt = n_cnt; m_peak = n_peak; e_sv = 0;
        end
        e_vo = int'(v); e_io = int'(i); e_qo = int'(q);
        @(negedge clk);
        check_all(scn);
    endtask

    task automatic model_reset();
        m_cnt = 0; m_peak = 0;
        e_sc = 0; e_sp = 0; e_sv = 0; e_vo = 0; e_io = 0; e_qo = 0;
    endtask

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        check_all("R9 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R9 after release");

        // R3/R1/R2: peak tracking with mixed signs, invalid samples ignored
        step(1, 16'd100,  16'hFF00, 0, 0, 0, "R2 q larger");      // |Q|=256
        step(0, 16'h7FFF, 16'd0,    0, 0, 0, "R3 invalid big");
        step(1, 16'd200,  16'd5,    0, 0, 0, "R3 smaller kept");
        step(1, 16'hFC18, 16'd10,   0, 0, 0, "R1 negative");      // 1000
        step(1, 16'd1000, 16'd0,    0, 0, 0, "R3 equal no change");
        // R4: overflow counting, flags on invalid samples ignored
        step(1, 16'd1, 16'd1, 1, 0, 0, "R4 ovf_i");
        step(1, 16'd1, 16'd1, 0, 1, 0, "R4 ovf_q");
        step(1, 16'd1, 16'd1, 1, 1, 0, "R4 both");
        step(0, 16'd1, 16'd1, 1, 1, 0, "R4 invalid ovf");
        // R5/R6: strobe with no sample, then hold
        step(0, 16'd0, 16'd0, 0, 0, 1, "R6 snapshot");
        step(0, 16'd0, 16'd0, 0, 0, 0, "R6 hold");
        step(1, 16'd3, 16'd3, 0, 0, 0, "R6 hold new frame");
        step(0, 16'd0, 16'd0, 0, 0, 1, "R6 second snapshot");
        // R7: coincident sample folded into snapshot only
        step(1, 16'd50, 16'd0, 0, 0, 0, "R7 pre");
        step(1, 16'h9000, 16'd7, 1, 0, 1, "R7 coincident");
        step(1, 16'd2, 16'd0, 0, 0, 0, "R7 next frame");
        step(0, 16'd0, 16'd0, 0, 0, 1, "R7 not carried");
        // R1: most negative code clamps
        step(1, 16'h8000, 16'd0, 0, 0, 0, "R1 min code");
        step(1, 16'd0, 16'h8000, 0, 0, 1, "R1 min code q");
        // R4: saturation at 255
        for (int k = 0; k < 300; k++)
            step(1, 16'd4, 16'd4, k[0], ~k[0], 0, "R4 saturate");
        step(1, 16'd4, 16'd4, 1, 1, 1, "R4 saturated snapshot");
        // R9: asynchronous reset mid frame
        step(1, 16'd900, 16'd0, 1, 0, 0, "R9 pre reset");
        rst_n = 1'b0;
        #1;
        model_reset();
        check_all("R9 async");
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 16'd0, 16'd0, 0, 0, 1, "R9 cleared frame");
        // mixed random traffic against the model (R3 R4 R7 R8)
        for (int k = 0; k < 3000; k++)
            step(logic'($urandom_range(0, 3) != 0), 16'($urandom), 16'($urandom),
                 logic'($urandom_range(0, 1)), logic'($urandom_range(0, 3) == 0),
                 logic'($urandom_range(0, 40) == 0), "R7 random");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule